// File: doc/BRIEF.md
# Framed Serial Codec Link Master

This block drives a synchronous serial link to one or two codec devices and is always the master of that link. It divides the master clock down to a serial clock, emits a one-bit-wide frame sync, shifts transmit bits out, and samples receive bits back in. Every frame is 128 serial clocks long. It is split into two 64-bit subframes, one per attached device.

Subframe 0 carries the audio channel and subframe 1 carries the telecom channel. Each subframe starts with a 16-bit control word going out and a 16-bit status word coming in. The 16-bit sample slot follows. The CPU side sees plain holding registers for these words: transmit values are written through a shared write bus with one strobe per register, and received values appear as outputs with a valid flag and a read acknowledge.

All transfers between the holding registers and the serial shadow registers happen on a single one-clock frame strobe. That strobe also raises an underrun or overrun flag when software has not kept pace with the link.

Top module: `sfx_link_master`

## Requirements
- R1: With divider input N, the serial clock is high for N+1 master clocks and low for N+1 master clocks, so one serial period is 2(N+1) master clocks.
- R2: The sync output is high for exactly one serial clock period, every 128 serial periods. That period is the one just before bit 0 of a frame.
- R3: Transmit bit order within the frame, most significant bit first:
  - bits 0-15 carry control word 0;
  - bits 16-31 carry the audio sample;
  - bits 64-79 carry control word 1;
  - bits 80-95 carry the telecom sample;
  - bits 32-63 and 96-127 are zero.
- R4: The data output changes only on a rising serial clock edge. The data input is sampled on the falling edge.
- R5: Received bits 0-15 become status word 0, bits 16-31 the audio sample, bits 64-79 status word 1, and bits 80-95 the telecom sample. Bits 32-63 and 96-127 are ignored.
- R6: With a channel's narrow select high, that channel sends its holding register's low byte as {byte, 8'h00}. It returns the received slot's upper byte as {8'h00, byte}.
- R7: A one-clock frame strobe coincides with the rise of sync. It copies the transmit holding registers and control words into the frame that follows, and publishes the previous frame's received words.
- R8: If a transmit holding register was not written since the previous strobe, the strobe sets that channel's sticky underrun flag, and the old value is sent again.
- R9: A strobe sets the channel's receive valid flag. If valid was still set and not being acknowledged, the strobe also sets the sticky overrun flag. A read acknowledge clears valid.
- R10: The flag clear input clears all four underrun and overrun flags. It overrides a strobe in the same cycle.
- R11: After reset the following outputs are all low:
  - the serial clock, sync, data output and frame strobe;
  - both valid flags;
  - all four error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| div_val | input | DIVW | Divider N, serial period 2(N+1) clocks |
| aud_narrow | input | 1 | Audio channel uses 8-bit samples |
| tel_narrow | input | 1 | Telecom channel uses 8-bit samples |
| wdata | input | 16 | Shared write data |
| wr_aud | input | 1 | Write audio transmit holding register |
| wr_tel | input | 1 | Write telecom transmit holding register |
| wr_ctl0 | input | 1 | Write control word 0 |
| wr_ctl1 | input | 1 | Write control word 1 |
| rd_aud | input | 1 | Acknowledge audio receive word |
| rd_tel | input | 1 | Acknowledge telecom receive word |
| flag_clr | input | 1 | Clear underrun and overrun flags |
| ctl0_q | output | 16 | Control word 0 readback |
| ctl1_q | output | 16 | Control word 1 readback |
| stat0 | output | 16 | Status word received in subframe 0 |
| stat1 | output | 16 | Status word received in subframe 1 |
| aud_rx | output | 16 | Audio receive holding register |
| tel_rx | output | 16 | Telecom receive holding register |
| aud_rx_valid | output | 1 | Audio receive word unread |
| tel_rx_valid | output | 1 | Telecom receive word unread |
| aud_under | output | 1 | Audio transmit underrun, sticky |
| tel_under | output | 1 | Telecom transmit underrun, sticky |
| aud_over | output | 1 | Audio receive overrun, sticky |
| tel_over | output | 1 | Telecom receive overrun, sticky |
| frame_stb | output | 1 | One-clock frame boundary strobe |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |

## Verification
The divider is exercised with N = 0, 1 and 3. Measuring the high time, low time, sync width and rises per frame at each setting separates an off-by-one in the count from a wrong toggle point.

Frames are exchanged with distinct values in every slot, and all-ones patterns are driven into the pad regions. This exposes swapped slots, a bit-reversed shift, a shift taken on the wrong clock edge, and pad bits leaking into received words.

Narrow-mode frames show whether the byte lands in the upper or the lower half of the slot. Frames skipped on either side show that the service flags latch and that stale data is repeated.

// File: rtl/sfx_link_master.sv
module sfx_link_master #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_val,
  input  logic            aud_narrow,
  input  logic            tel_narrow,
  input  logic [15:0]     wdata,
  input  logic            wr_aud,
  input  logic            wr_tel,
  input  logic            wr_ctl0,
  input  logic            wr_ctl1,
  input  logic            rd_aud,
  input  logic            rd_tel,
  input  logic            flag_clr,
  output logic [15:0]     ctl0_q,
  output logic [15:0]     ctl1_q,
  output logic [15:0]     stat0,
  output logic [15:0]     stat1,
  output logic [15:0]     aud_rx,
  output logic [15:0]     tel_rx,
  output logic            aud_rx_valid,
  output logic            tel_rx_valid,
  output logic            aud_under,
  output logic            tel_under,
  output logic            aud_over,
  output logic            tel_over,
  output logic            frame_stb,
  output logic            sclk,
  output logic            fsync,
  output logic            sdout,
  input  logic            sdin
);

  localparam int FBITS = 128;
  localparam int PW    = $clog2(FBITS);
  localparam logic [PW-1:0] LAST = PW'(FBITS - 1);

  logic [DIVW-1:0] cnt;
  logic [PW-1:0]   pos;
  logic [15:0]     aud_tx, tel_tx;
  logic            aud_full, tel_full;
  logic [15:0]     sh_c0, sh_a, sh_c1, sh_t;
  logic [15:0]     r_c0, r_a, r_c1, r_t;

  wire            tick  = (cnt >= div_val);
  wire            rise  = tick & ~sclk;
  wire            fall  = tick & sclk;
  wire [PW-1:0]   pos_n = pos + 1'b1;
  wire [FBITS-1:0] tx_frame = {sh_c0, sh_a, 32'h0, sh_c1, sh_t, 32'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sclk      <= 1'b0;
      pos       <= LAST - 1'b1;
      sdout     <= 1'b0;
      fsync     <= 1'b0;
      frame_stb <= 1'b0;
    end else begin
      cnt       <= tick ? '0 : cnt + 1'b1;
      if (tick) sclk <= ~sclk;
      frame_stb <= rise && (pos_n == LAST);
      if (rise) begin
        pos   <= pos_n;
        sdout <= tx_frame[LAST - pos_n];
        fsync <= (pos_n == LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_c0 <= '0; r_a <= '0; r_c1 <= '0; r_t <= '0;
    end else if (fall && !pos[5]) begin
      case ({pos[6], pos[4]})
        2'b00:   r_c0 <= {r_c0[14:0], sdin};
        2'b01:   r_a  <= {r_a[14:0], sdin};
        2'b10:   r_c1 <= {r_c1[14:0], sdin};
        default: r_t  <= {r_t[14:0], sdin};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aud_tx <= '0; tel_tx <= '0; ctl0_q <= '0; ctl1_q <= '0;
      aud_full <= 1'b0; tel_full <= 1'b0;
    end else begin
      if (wr_aud)  aud_tx <= wdata;
      if (wr_tel)  tel_tx <= wdata;
      if (wr_ctl0) ctl0_q <= wdata;
      if (wr_ctl1) ctl1_q <= wdata;
      if (wr_aud) aud_full <= 1'b1; else if (frame_stb) aud_full <= 1'b0;
      if (wr_tel) tel_full <= 1'b1; else if (frame_stb) tel_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_c0 <= '0; sh_a <= '0; sh_c1 <= '0; sh_t <= '0;
      stat0 <= '0; stat1 <= '0; aud_rx <= '0; tel_rx <= '0;
    end else if (frame_stb) begin
      sh_c0  <= ctl0_q;
      sh_c1  <= ctl1_q;
      sh_a   <= aud_narrow ? {aud_tx[7:0], 8'h00} : aud_tx;
      sh_t   <= tel_narrow ? {tel_tx[7:0], 8'h00} : tel_tx;
      stat0  <= r_c0;
      stat1  <= r_c1;
      aud_rx <= aud_narrow ? {8'h00, r_a[15:8]} : r_a;
      tel_rx <= tel_narrow ? {8'h00, r_t[15:8]} : r_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aud_rx_valid <= 1'b0; tel_rx_valid <= 1'b0;
      aud_under <= 1'b0; tel_under <= 1'b0;
      aud_over  <= 1'b0; tel_over  <= 1'b0;
    end else begin
      if (frame_stb) aud_rx_valid <= 1'b1; else if (rd_aud) aud_rx_valid <= 1'b0;
      if (frame_stb) tel_rx_valid <= 1'b1; else if (rd_tel) tel_rx_valid <= 1'b0;
      if (flag_clr) begin
        aud_under <= 1'b0; tel_under <= 1'b0;
        aud_over  <= 1'b0; tel_over  <= 1'b0;
      end else if (frame_stb) begin
        if (!aud_full) aud_under <= 1'b1;
        if (!tel_full) tel_under <= 1'b1;
        if (aud_rx_valid && !rd_aud) aud_over <= 1'b1;
        if (tel_rx_valid && !rd_tel) tel_over <= 1'b1;
      end
    end
  end

  assert_sdout_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $rose(sclk));
  assert_strobe_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> $rose(fsync));
  assert_sync_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> (pos == '0));
  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos[5] |-> !sdout);
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !(aud_under || tel_under || aud_over || tel_over));
  assert_valid_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aud_rx_valid) |-> $past(frame_stb));

endmodule

// File: tb/sfx_link_master_bench.sv
module sfx_link_master_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] div_val = 8'd1;
  logic aud_narrow = 1'b0, tel_narrow = 1'b0;
  logic [15:0] wdata = '0;
  logic wr_aud = 0, wr_tel = 0, wr_ctl0 = 0, wr_ctl1 = 0;
  logic rd_aud = 0, rd_tel = 0, flag_clr = 0;
  logic [15:0] ctl0_q, ctl1_q, stat0, stat1, aud_rx, tel_rx;
  logic aud_rx_valid, tel_rx_valid, aud_under, tel_under, aud_over, tel_over;
  logic frame_stb, sclk, fsync, sdout;
  logic sdin = 1'b0;

  sfx_link_master #(.DIVW(8)) u_sfx_link_master (
    .clk, .rst_n, .div_val, .aud_narrow, .tel_narrow, .wdata,
    .wr_aud, .wr_tel, .wr_ctl0, .wr_ctl1, .rd_aud, .rd_tel, .flag_clr,
    .ctl0_q, .ctl1_q, .stat0, .stat1, .aud_rx, .tel_rx,
    .aud_rx_valid, .tel_rx_valid, .aud_under, .tel_under, .aud_over, .tel_over,
    .frame_stb, .sclk, .fsync, .sdout, .sdin);

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial-side model of the attached codecs
  logic [127:0] rx_pat = '0, cur_cap = '0, last_cap = '0;
  logic prev_sclk = 0, prev_fsync = 0, prev_sdout = 0, synced = 0;
  int cyc = 0, last_rise = 0, last_fall = 0, hi_len = 0, lo_len = 0;
  int fs_start = 0, fs_len = 0, rc = 0, frame_rises = 0, bidx = 0, edge_err = 0;

  always @(negedge clk) begin
    logic r, f;
    cyc++;
    r = sclk && !prev_sclk;
    f = !sclk && prev_sclk;
    if (rst_n) begin
      if (r) begin
        lo_len = cyc - last_fall;
        last_rise = cyc;
        if (fsync) begin
          if (synced) begin last_cap = cur_cap; frame_rises = rc; end
          synced = 1; rc = 1; bidx = 0; fs_start = cyc;
        end else begin
          rc++;
          if (synced && bidx < 127) begin
            cur_cap[127-bidx] = sdout;
            sdin = rx_pat[127-bidx];
            bidx++;
          end
        end
      end
      if (f) begin hi_len = cyc - last_rise; last_fall = cyc; end
      if (prev_fsync && !fsync) fs_len = cyc - fs_start;
      if (sdout !== prev_sdout && !r) edge_err++;
    end
    prev_sclk = sclk; prev_fsync = fsync; prev_sdout = sdout;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=%0d expected=<150000", wd);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_stb();
    @(negedge clk);
    while (!frame_stb) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input int which, input logic [15:0] d);
    wdata = d;
    case (which)
      0: wr_aud = 1; 1: wr_tel = 1; 2: wr_ctl0 = 1; default: wr_ctl1 = 1;
    endcase
    @(negedge clk);
    wr_aud = 0; wr_tel = 0; wr_ctl0 = 0; wr_ctl1 = 0;
  endtask

  task automatic ack_all();
    rd_aud = 1; rd_tel = 1; @(negedge clk); rd_aud = 0; rd_tel = 0;
  endtask

  task automatic clr_flags();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11 sclk", sclk, 0);
    chk("R11 fsync", fsync, 0);
    chk("R11 sdout", sdout, 0);
    chk("R11 frame_stb", frame_stb, 0);
    chk("R11 valid", {aud_rx_valid, tel_rx_valid}, 0);
    chk("R11 flags", {aud_under, tel_under, aud_over, tel_over}, 0);
    rst_n = 1;
  endtask

  task automatic t_timing(input int n);
    wait_stb();
    div_val = 8'(n);
    wait_stb(); wait_stb(); wait_stb();
    chk("R1 sclk high time", hi_len, n + 1);
    chk("R1 sclk low time", lo_len, n + 1);
    chk("R2 sync width", fs_len, 2 * (n + 1));
    chk("R2 rises per frame", frame_rises, 128);
  endtask

  task automatic t_xfer(input logic narrow, input logic [15:0] c0, a, c1, t,
                        input logic [15:0] s0, ra, s1, rt);
    wait_stb();
    aud_narrow = narrow; tel_narrow = narrow;
    rx_pat = {s0, ra, 32'hFFFF_FFFF, s1, rt, 32'hFFFF_FFFF};
    wr(2, c0); wr(0, a); wr(3, c1); wr(1, t);
    wait_stb();
    ack_all();
    wait_stb();
    chk("R3 ctl0 slot", last_cap[127:112], c0);
    chk("R3 ctl1 slot", last_cap[63:48], c1);
    chk("R3 pad 32-63", last_cap[95:64], 0);
    chk("R3 pad 96-126", {1'b0, last_cap[31:1]}, 0);
    if (narrow) begin
      chk("R6 narrow audio tx", last_cap[111:96], {a[7:0], 8'h00});
      chk("R6 narrow tel tx", last_cap[47:32], {t[7:0], 8'h00});
      chk("R6 narrow audio rx", aud_rx, {8'h00, ra[15:8]});
      chk("R6 narrow tel rx", tel_rx, {8'h00, rt[15:8]});
    end else begin
      chk("R3 audio slot", last_cap[111:96], a);
      chk("R3 tel slot", last_cap[47:32], t);
      chk("R5 audio rx", aud_rx, ra);
      chk("R5 tel rx", tel_rx, rt);
    end
    chk("R5 status0", stat0, s0);
    chk("R5 status1", stat1, s1);
    chk("R7 ctl readback", {ctl0_q, ctl1_q}, {c0, c1});
    chk("R9 valid after strobe", {aud_rx_valid, tel_rx_valid}, 2'b11);
    ack_all();
  endtask

  task automatic t_underrun();
    aud_narrow = 0; tel_narrow = 0;
    wait_stb();
    ack_all(); clr_flags();
    wr(0, 16'h3C5A); wr(1, 16'hB00F);
    wait_stb();
    chk("R8 no underrun when written", {aud_under, tel_under}, 0);
    ack_all();
    wait_stb();
    chk("R8 underrun set", {aud_under, tel_under}, 2'b11);
    chk("R8 fresh value sent", last_cap[111:96], 16'h3C5A);
    ack_all();
    wait_stb();
    chk("R8 old value resent", last_cap[111:96], 16'h3C5A);
    chk("R8 old tel resent", last_cap[47:32], 16'hB00F);
    chk("R8 flag sticky", aud_under, 1);
    ack_all();
  endtask

  task automatic t_overrun();
    wait_stb();
    ack_all(); clr_flags();
    wait_stb();
    chk("R9 no overrun when read", {aud_over, tel_over}, 0);
    wait_stb();
    chk("R9 overrun set", {aud_over, tel_over}, 2'b11);
    rd_aud = 1; @(negedge clk); rd_aud = 0; @(negedge clk);
    chk("R9 ack clears valid", {aud_rx_valid, tel_rx_valid}, 2'b01);
    clr_flags(); @(negedge clk);
    chk("R10 flags cleared", {aud_under, tel_under, aud_over, tel_over}, 0);
    ack_all();
  endtask

  initial begin
    t_reset();
    t_timing(3);
    t_timing(0);
    t_timing(1);
    t_xfer(0, 16'hA1B2, 16'hC3D4, 16'h1357, 16'h2468,
              16'h8421, 16'h5AA5, 16'h0F0F, 16'hE001);
    t_xfer(0, 16'h8000, 16'h0001, 16'hFFFF, 16'h7FFE,
              16'h0001, 16'h8000, 16'h6996, 16'h1234);
    t_xfer(1, 16'h4242, 16'h99A5, 16'h0101, 16'h773C,
              16'hBEEF, 16'h7C11, 16'hCAFE, 16'h9E22);
    t_underrun();
    t_overrun();
    chk("R4 sdout only on rising sclk", edge_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule